// File: doc/BRIEF.md
# Block Address Translation Matcher

This block translates an effective address through a small set of large-block mapping entries before page translation is tried. It holds two banks of four entries each: one bank serves instruction fetches and the other serves data accesses. Each entry is a pair of 32-bit words. The upper word says which effective region the entry covers and who may use it. The lower word gives the physical block number and the access rights.

Software loads the entries through a plain write port that selects the bank, the entry, and the upper or lower word. For each access, the requester presents an effective address, a bank select, a write flag and a user/supervisor flag. One cycle later the block reports one of two outcomes:

- a hit, with the physical address, the read and write rights, and a protection-fault flag;
- a miss, which the surrounding logic hands on to page translation.

Field layout of an entry:
- Upper word: bits 31:28 are the exact top tag. Bits 27:17 are the middle tag. Bits 12:2 are the block-length mask, which lines up with address bits 27:17. Bit 1 is supervisor-valid and bit 0 is user-valid.
- Lower word: bits 31:17 are the physical block number. Bits 1:0 are the rights.

Top module: `blkx_matcher`

## Requirements
- R1: The bank is chosen by `acc_is_data`: 0 uses the instruction bank and 1 uses the data bank. The write port selects its bank with `wr_bank` using the same encoding, and `wr_word` = 1 selects the upper word.
- R2: Address bits 31:28 must equal upper-word bits 31:28 exactly, whatever the block-length mask holds.
- R3: Upper-word bits 12:2 form the block-length mask for address bits 27:17. The entry matches when (address bits 27:17 AND NOT mask) equals upper-word bits 27:17.
- R4: On a hit, the physical address is built as follows:
  - bits 31:28 come from lower-word bits 31:28;
  - bits 27:17 are (lower-word bits 27:17 AND NOT mask) OR (address bits 27:17 AND mask);
  - bits 16:0 are the address bits 16:0.
- R5: A supervisor access (`acc_user` = 0) can match only an entry whose upper bit 1 is set. A user access (`acc_user` = 1) can match only an entry whose upper bit 0 is set.
- R6: When several entries of the selected bank match, the lowest-numbered one is used.
- R7: The rights come from lower bits 1:0 of the matching entry:
  - bit 1 set gives read and write;
  - the value 01 gives read only;
  - the value 00 gives no access.
- R8: On a hit, `res_fault` is 1 in two cases: a write to an entry without write right, or a read from an entry with no access.
- R9: On a miss, `res_hit`, `res_paddr`, both rights and `res_fault` are all 0.
- R10: The result of an access sampled with `acc_valid` = 1 appears one cycle later with `res_valid` = 1. A cycle with `acc_valid` = 0 gives `res_valid` = 0. A register write takes effect for accesses sampled on the next clock edge.
- R11: Synchronous active-low reset clears every entry, so every entry is invalid, and clears all result outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_bank | input | 1 | Bank to write: 0 instruction, 1 data |
| wr_idx | input | 2 | Entry number to write |
| wr_word | input | 1 | Word to write: 1 upper, 0 lower |
| wr_data | input | 32 | Value to write |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_ea | input | 32 | Effective address of the access |
| acc_is_data | input | 1 | 0 instruction fetch, 1 data access |
| acc_write | input | 1 | Access is a write |
| acc_user | input | 1 | Access is made in user mode |
| res_valid | output | 1 | The result outputs belong to the access of the previous cycle |
| res_hit | output | 1 | An entry matched |
| res_paddr | output | 32 | Translated physical address |
| res_can_read | output | 1 | The matched block grants read |
| res_can_write | output | 1 | The matched block grants write |
| res_fault | output | 1 | The access violates the block rights |

## Verification
Every result output is registered once, so the result of an access sampled on a rising edge is due on the outputs right after that edge. The bench drives each access on a falling edge and reads the outputs on the next falling edge, half a period after the capturing edge. Entry writes are also driven on a falling edge. Each access that depends on a write is presented no earlier than the following falling edge, which is the first cycle in which R10 promises the new value.

// File: rtl/blkx_pkg.sv
// Package blkx_pkg
// Shared geometry and field positions of the block translation entries.
// Assumes a 32-bit address split into a 4-bit exact tag, an 11-bit maskable
// middle tag and a 17-bit in-block offset.
package blkx_pkg;
    localparam int TOP_W  = 4;
    localparam int MID_W  = 11;
    localparam int OFF_W  = 17;
    localparam int ADDR_W = TOP_W + MID_W + OFF_W;
    localparam int N_ENT  = 4;
    localparam int IDX_W  = $clog2(N_ENT);
    localparam int BL_LSB = 2;
    localparam int VS_BIT = 1;
    localparam int VU_BIT = 0;

    typedef logic [ADDR_W-1:0] word_t;

    // Rights granted by a block, from lower-word bits 1:0
    typedef struct packed {
        logic rd;
        logic wr;
    } rights_t;

    // Decode lower-word rights bits
    function automatic rights_t decode_rights(input logic [1:0] pp);
        rights_t r;
        r.wr = pp[1];
        r.rd = pp[1] | pp[0];
        return r;
    endfunction
endpackage

// File: rtl/blkx_regfile.sv
// Module blkx_regfile
// Holds both banks of upper/lower entry words and presents the bank selected
// by the current access. Assumes one write per cycle; writes are visible on
// the read side from the following cycle.
module blkx_regfile
    import blkx_pkg::*;
#(
    parameter int N   = N_ENT,
    parameter int IW  = IDX_W,
    parameter int AW  = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_word,
    input  logic [AW-1:0] wr_data,
    input  logic          rd_bank,
    output logic [AW-1:0] rd_upper [N],
    output logic [AW-1:0] rd_lower [N]
);
    localparam int BANKS = 2;

    logic [AW-1:0] upr_q [BANKS][N];
    logic [AW-1:0] lwr_q [BANKS][N];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        for (genvar e = 0; e < N; e++) begin : g_ent
            // Store one upper/lower pair; reset leaves it invalid
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    upr_q[b][e] <= '0;
                    lwr_q[b][e] <= '0;
                end else if (wr_en && (wr_bank == 1'(b)) && (wr_idx == IW'(e))) begin
                    if (wr_word) upr_q[b][e] <= wr_data;
                    else         lwr_q[b][e] <= wr_data;
                end
            end
        end
    end

    // Route the bank chosen by the access type to the comparators
    always_comb begin
        for (int e = 0; e < N; e++) begin
            rd_upper[e] = upr_q[rd_bank][e];
            rd_lower[e] = lwr_q[rd_bank][e];
        end
    end
endmodule

// File: rtl/blkx_entry_cmp.sv
// Module blkx_entry_cmp
// Compares one entry against an effective address and forms the physical
// address and rights it would give. Assumes the upper/lower field layout of
// blkx_pkg; the top tag is never masked.
module blkx_entry_cmp
    import blkx_pkg::*;
#(
    parameter int TW = TOP_W,
    parameter int MW = MID_W,
    parameter int OW = OFF_W,
    localparam int AW = TW + MW + OW
) (
    input  logic [AW-1:0] upper,
    input  logic [AW-1:0] lower,
    input  logic [AW-1:0] ea,
    input  logic          user,
    output logic          hit,
    output logic [AW-1:0] paddr,
    output logic [1:0]    pp
);
    logic [TW-1:0] tag_top, ea_top, brpn_top;
    logic [MW-1:0] tag_mid, ea_mid, brpn_mid, blmask;
    logic          ent_ok, top_eq, mid_eq;
    logic          unused_fields;

    // Slice the entry and address into their fields
    always_comb begin
        tag_top  = upper[AW-1 -: TW];
        tag_mid  = upper[OW +: MW];
        blmask   = upper[BL_LSB +: MW];
        brpn_top = lower[AW-1 -: TW];
        brpn_mid = lower[OW +: MW];
        ea_top   = ea[AW-1 -: TW];
        ea_mid   = ea[OW +: MW];
    end

    assign unused_fields = ^{upper[OW-1:BL_LSB+MW], lower[OW-1:2]};

    // Privilege check and masked tag compare
    always_comb begin
        ent_ok = user ? upper[VU_BIT] : upper[VS_BIT];
        top_eq = (ea_top == tag_top);
        mid_eq = ((ea_mid & ~blmask) == tag_mid);
        hit    = ent_ok && top_eq && mid_eq;
    end

    // Physical address: block number outside the mask, address inside it
    always_comb begin
        paddr = {brpn_top, (brpn_mid & ~blmask) | (ea_mid & blmask), ea[OW-1:0]};
        pp    = lower[1:0];
    end
endmodule

// File: rtl/blkx_first_hit.sv
// Module blkx_first_hit
// Picks the lowest-numbered matching entry and forwards its physical address
// and rights bits. Assumes inputs are all from one bank.
module blkx_first_hit
    import blkx_pkg::*;
#(
    parameter int N  = N_ENT,
    parameter int AW = ADDR_W
) (
    input  logic [N-1:0]  hits,
    input  logic [AW-1:0] paddrs [N],
    input  logic [1:0]    pps    [N],
    output logic          any_hit,
    output logic [AW-1:0] sel_paddr,
    output logic [1:0]    sel_pp
);
    // Scan from the top down so the lowest index is written last and wins
    always_comb begin
        any_hit   = 1'b0;
        sel_paddr = '0;
        sel_pp    = 2'b00;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any_hit   = 1'b1;
                sel_paddr = paddrs[i];
                sel_pp    = pps[i];
            end
        end
    end
endmodule

// File: rtl/blkx_rights.sv
// Module blkx_rights
// Turns the selected rights bits and the access direction into read/write
// grants and a fault flag. Assumes everything is zero on a miss.
module blkx_rights
    import blkx_pkg::*;
(
    input  logic       hit,
    input  logic [1:0] pp,
    input  logic       is_write,
    output logic       can_rd,
    output logic       can_wr,
    output logic       fault
);
    rights_t r;

    // Decode rights and flag any access the block forbids
    always_comb begin
        r      = decode_rights(pp);
        can_rd = hit & r.rd;
        can_wr = hit & r.wr;
        fault  = hit & (is_write ? ~r.wr : ~r.rd);
    end
endmodule

// File: rtl/blkx_matcher.sv
// Module blkx_matcher (top)
// Block address translation matcher: two banks of four entries, a masked
// compare per entry, first-match selection and rights decode, with one
// register stage on the result. Assumes a miss is handled downstream.
module blkx_matcher
    import blkx_pkg::*;
#(
    parameter int N  = N_ENT,
    parameter int IW = IDX_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_word,
    input  logic [AW-1:0] wr_data,
    input  logic          acc_valid,
    input  logic [AW-1:0] acc_ea,
    input  logic          acc_is_data,
    input  logic          acc_write,
    input  logic          acc_user,
    output logic          res_valid,
    output logic          res_hit,
    output logic [AW-1:0] res_paddr,
    output logic          res_can_read,
    output logic          res_can_write,
    output logic          res_fault
);
    logic [AW-1:0] ent_upper [N];
    logic [AW-1:0] ent_lower [N];
    logic [N-1:0]  ent_hit;
    logic [AW-1:0] ent_paddr [N];
    logic [1:0]    ent_pp    [N];
    logic          any_hit;
    logic [AW-1:0] sel_paddr;
    logic [1:0]    sel_pp;
    logic          can_rd, can_wr, fault;

    blkx_regfile #(.N(N), .IW(IW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_bank  (wr_bank),
        .wr_idx   (wr_idx),
        .wr_word  (wr_word),
        .wr_data  (wr_data),
        .rd_bank  (acc_is_data),
        .rd_upper (ent_upper),
        .rd_lower (ent_lower)
    );

    for (genvar e = 0; e < N; e++) begin : g_cmp
        blkx_entry_cmp u_cmp (
            .upper (ent_upper[e]),
            .lower (ent_lower[e]),
            .ea    (acc_ea),
            .user  (acc_user),
            .hit   (ent_hit[e]),
            .paddr (ent_paddr[e]),
            .pp    (ent_pp[e])
        );
    end

    blkx_first_hit #(.N(N), .AW(AW)) u_pick (
        .hits      (ent_hit),
        .paddrs    (ent_paddr),
        .pps       (ent_pp),
        .any_hit   (any_hit),
        .sel_paddr (sel_paddr),
        .sel_pp    (sel_pp)
    );

    blkx_rights u_rights (
        .hit      (any_hit),
        .pp       (sel_pp),
        .is_write (acc_write),
        .can_rd   (can_rd),
        .can_wr   (can_wr),
        .fault    (fault)
    );

    // Register the result of the access presented this cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid     <= 1'b0;
            res_hit       <= 1'b0;
            res_paddr     <= '0;
            res_can_read  <= 1'b0;
            res_can_write <= 1'b0;
            res_fault     <= 1'b0;
        end else begin
            res_valid     <= acc_valid;
            res_hit       <= acc_valid & any_hit;
            res_paddr     <= (acc_valid & any_hit) ? sel_paddr : '0;
            res_can_read  <= acc_valid & can_rd;
            res_can_write <= acc_valid & can_wr;
            res_fault     <= acc_valid & fault;
        end
    end
endmodule

// File: rtl/blkx_matcher_chk.sv
// Module blkx_matcher_chk
// Temporal checks on the matcher ports, bound to every instance of the top.
module blkx_matcher_chk
    import blkx_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_valid,
    input logic [AW-1:0] acc_ea,
    input logic          acc_write,
    input logic          res_valid,
    input logic          res_hit,
    input logic [AW-1:0] res_paddr,
    input logic          res_can_read,
    input logic          res_can_write,
    input logic          res_fault
);
    // R10: a result follows every sampled access, and only those
    assert_result_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);
    assert_no_spurious_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid);

    // R9: a miss carries no address, rights or fault
    assert_miss_is_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_paddr == '0) && !res_can_read && !res_can_write && !res_fault);

    // R4: the in-block offset passes through unchanged
    assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> res_paddr[OFF_W-1:0] == $past(acc_ea[OFF_W-1:0]));

    // R7: write right never comes without read right
    assert_write_implies_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_can_write |-> res_can_read);

    // R8: a fault matches the direction and the rights of the access
    assert_fault_consistent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |->
            (res_fault == ($past(acc_write) ? !res_can_write : !res_can_read)));
endmodule

bind blkx_matcher blkx_matcher_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_ea        (acc_ea),
    .acc_write     (acc_write),
    .res_valid     (res_valid),
    .res_hit       (res_hit),
    .res_paddr     (res_paddr),
    .res_can_read  (res_can_read),
    .res_can_write (res_can_write),
    .res_fault     (res_fault)
);

// File: tb/sim_blkx_matcher.sv
// Directed bench for blkx_matcher: one task per scenario.
module sim_blkx_matcher;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_bank = 1'b0, wr_word = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        acc_valid = 1'b0, acc_is_data = 1'b0, acc_write = 1'b0, acc_user = 1'b0;
    logic [31:0] acc_ea = '0;
    logic        res_valid, res_hit, res_can_read, res_can_write, res_fault;
    logic [31:0] res_paddr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blkx_matcher u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_word(wr_word), .wr_data(wr_data),
        .acc_valid(acc_valid), .acc_ea(acc_ea), .acc_is_data(acc_is_data),
        .acc_write(acc_write), .acc_user(acc_user),
        .res_valid(res_valid), .res_hit(res_hit), .res_paddr(res_paddr),
        .res_can_read(res_can_read), .res_can_write(res_can_write), .res_fault(res_fault)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Write one entry word on a falling edge; visible from the next edge on
    task automatic put(input bit bank, input int idx, input bit upper, input logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_bank = bank; wr_idx = 2'(idx); wr_word = upper; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Present an access for one cycle and check the result one edge later
    task automatic probe(input string req, input logic [31:0] ea, input bit dside, input bit wr,
                         input bit usr, input bit ehit, input logic [31:0] epa,
                         input bit erd, input bit ewr, input bit eflt);
        @(negedge clk);
        acc_valid = 1'b1; acc_ea = ea; acc_is_data = dside; acc_write = wr; acc_user = usr;
        @(negedge clk);
        acc_valid = 1'b0;
        chk(req, "valid", 32'(res_valid), 32'd1);
        chk(req, "hit",   32'(res_hit),   32'(ehit));
        chk(req, "paddr", res_paddr,      epa);
        chk(req, "rd",    32'(res_can_read),  32'(erd));
        chk(req, "wr",    32'(res_can_write), 32'(ewr));
        chk(req, "fault", 32'(res_fault),     32'(eflt));
    endtask

    // R11: reset state and empty banks
    task automatic t_reset();
        chk("R11", "valid in reset", 32'(res_valid), 32'd0);
        chk("R11", "hit in reset", 32'(res_hit), 32'd0);
        probe("R11", 32'h0000_0000, 1'b0, 1'b0, 1'b0, 0, 0, 0, 0, 0);
        probe("R11", 32'h0000_0000, 1'b1, 1'b0, 1'b1, 0, 0, 0, 0, 0);
    endtask

    // R1: same address, different bank, different translation
    task automatic t_banks();
        put(0, 0, 1, 32'h1000_0002); put(0, 0, 0, 32'h8000_0002);
        put(1, 0, 1, 32'h1000_0002); put(1, 0, 0, 32'h4000_0001);
        probe("R1", 32'h1000_1234, 1'b0, 1'b0, 1'b0, 1, 32'h8000_1234, 1, 1, 0);
        probe("R1", 32'h1000_1234, 1'b1, 1'b0, 1'b0, 1, 32'h4000_1234, 1, 0, 0);
    endtask

    // R2/R4: full mask still needs the top tag
    task automatic t_top_exact();
        put(1, 1, 1, 32'h2000_1FFE); put(1, 1, 0, 32'h6000_0002);
        probe("R2", 32'h2ABC_DEF0, 1'b1, 1'b0, 1'b0, 1, 32'h6ABC_DEF0, 1, 1, 0);
        probe("R2", 32'h3ABC_DEF0, 1'b1, 1'b0, 1'b0, 0, 0, 0, 0, 0);
    endtask

    // R3/R4: partial mask on the middle tag
    task automatic t_mid_mask();
        put(1, 2, 1, 32'h4040_000E); put(1, 2, 0, 32'h9000_0002);
        probe("R3", 32'h4046_1111, 1'b1, 1'b0, 1'b0, 1, 32'h9006_1111, 1, 1, 0);
        probe("R4", 32'h4040_0005, 1'b1, 1'b1, 1'b0, 1, 32'h9000_0005, 1, 1, 0);
        probe("R3", 32'h4048_0000, 1'b1, 1'b0, 1'b0, 0, 0, 0, 0, 0);
    endtask

    // R5: supervisor and user valid bits
    task automatic t_privilege();
        probe("R5", 32'h1000_0010, 1'b0, 1'b0, 1'b1, 0, 0, 0, 0, 0);
        put(1, 3, 1, 32'h5000_0001); put(1, 3, 0, 32'hA000_0002);
        probe("R5", 32'h5000_0010, 1'b1, 1'b0, 1'b1, 1, 32'hA000_0010, 1, 1, 0);
        probe("R5", 32'h5000_0010, 1'b1, 1'b0, 1'b0, 0, 0, 0, 0, 0);
    endtask

    // R6/R10: lowest index wins; invalidating it exposes the next
    task automatic t_priority();
        put(0, 2, 1, 32'h7000_0002); put(0, 2, 0, 32'hC000_0002);
        put(0, 1, 1, 32'h7000_0002); put(0, 1, 0, 32'hB000_0002);
        probe("R6", 32'h7000_0044, 1'b0, 1'b0, 1'b0, 1, 32'hB000_0044, 1, 1, 0);
        put(0, 1, 1, 32'h0000_0000);
        probe("R10", 32'h7000_0044, 1'b0, 1'b0, 1'b0, 1, 32'hC000_0044, 1, 1, 0);
    endtask

    // R7/R8: read-only and no-access blocks
    task automatic t_rights();
        probe("R8", 32'h1000_0100, 1'b1, 1'b1, 1'b0, 1, 32'h4000_0100, 1, 0, 1);
        probe("R7", 32'h1000_0100, 1'b1, 1'b0, 1'b0, 1, 32'h4000_0100, 1, 0, 0);
        put(0, 3, 1, 32'h8000_0002); put(0, 3, 0, 32'hD000_0000);
        probe("R7", 32'h8000_0200, 1'b0, 1'b0, 1'b0, 1, 32'hD000_0200, 0, 0, 1);
        probe("R8", 32'h8000_0200, 1'b0, 1'b1, 1'b0, 1, 32'hD000_0200, 0, 0, 1);
    endtask

    // R9/R10: miss and idle cycle
    task automatic t_miss_idle();
        probe("R9", 32'hF123_4567, 1'b1, 1'b1, 1'b0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R10", "idle valid", 32'(res_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_pre();
        rst_n = 1'b1;
        t_reset();
        t_banks();
        t_top_exact();
        t_mid_mask();
        t_privilege();
        t_priority();
        t_rights();
        t_miss_idle();
        done = 1'b1;
    end

    task automatic t_reset_pre();
        chk("R11", "valid held in reset", 32'(res_valid), 32'd0);
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule